// File: doc/BRIEF.md
# ADC Lane Framer

The framer takes one parallel conversion result per channel, delivered on a sample strobe, and sends each channel's word serially on a lane of its own. All lanes move together. They share a bit clock that changes level once per bit, so a receiver captures data on both edges. They also share a frame marker that runs at the sample rate and shows where each word starts. The fast serial rate is an enable input, `bit_en`, that pulses once per bit in the single system clock domain. Twelve pulses make one frame.

A word may arrive at any point in a frame. It is held in a staging register and moves into the shifters only at the next frame boundary. Two selectable test words can replace the data on every lane. While a test word is selected, the marker and bit clock run exactly as in normal operation, so a receiver can tune its capture phase against a known pattern. A power-down input sends the framer back to its start-of-frame state and drops the output enable, which stands in for tri-stated drivers.

Top module: `adc_lane_framer`

## Requirements
- R1: Lane `l` sends the word taken from `smp_data[l*12 +: 12]`, most significant bit first. One bit goes out per `bit_en` pulse, and all lanes advance together.
- R2: The first `bit_en` pulse after reset or power-down starts a frame. Counting bit positions 0..11 from that pulse, `frame_mk` is high at positions 0..5 and low at positions 6..11.
- R3: `bclk` is high at even bit positions and low at odd ones. It therefore changes level on every `bit_en` pulse and makes six periods per word.
- R4: A word captured on `smp_stb` is sent in the first frame that starts after the strobe cycle. The frame already in progress finishes with its own word.
- R5: When more than one strobe falls within a frame, only the last captured word is sent.
- R6: Pattern code 1 on `pat_sel`, sampled at the frame boundary, makes every lane send 1000 0000 0000 (mid-scale).
- R7: Pattern code 2 makes every lane send 1010 1010 1010.
- R8: Codes 0 and 3 both send the captured data unchanged (offset binary passes straight through).
- R9: While a test word is selected, `frame_mk` and `bclk` follow R2 and R3 without change.
- R10: While `pwr_dn` is high, from the next edge on, `out_en`, `lane_sd`, `frame_mk` and `bclk` are all low. `out_en` returns high one edge after `pwr_dn` falls.
- R11: During reset, `out_en`, `lane_sd`, `frame_mk` and `bclk` are low.
- R12: In a cycle without a `bit_en` pulse and without power-down, `lane_sd`, `frame_mk` and `bclk` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_en | input | 1 | One pulse per serial bit (12 per sample) |
| smp_stb | input | 1 | Captures `smp_data` into the staging register |
| smp_data | input | LANES*WORD_W | Parallel words, lane `l` in bits `l*WORD_W +: WORD_W` |
| pat_sel | input | 2 | 0 normal, 1 mid-scale word, 2 alternating word, 3 normal |
| pwr_dn | input | 1 | Power-down: idle outputs and restart framing |
| lane_sd | output | LANES | Serial data, one bit per lane |
| frame_mk | output | 1 | Frame marker, high during the first half of a word |
| bclk | output | 1 | Bit clock level, one change per bit |
| out_en | output | 1 | Output drivers enabled |

## Verification
The bench builds the framer with its defaults: four lanes of twelve bits. It pulses `bit_en` on every second clock, so each frame is 24 clocks long and every frame contains idle cycles in which the hold behaviour is visible. With four lanes, a single frame can mix all-ones, all-zeros, mid-scale and irregular words, and the bench can check that lanes never swap or share bits. Strobes are placed mid-frame, and sometimes two fall in one frame, which tests the boundary-only load and the rule that the last word wins. Every frame sent under a test pattern is also checked bit by bit for marker and clock timing.

// File: rtl/framer_pkg.sv
// framer_pkg: types shared by the lane framer blocks.
// Assumes a 2-bit test-pattern select, decoded at frame boundaries.
package framer_pkg;

    typedef enum logic [1:0] {
        PAT_NONE = 2'd0,
        PAT_MID  = 2'd1,
        PAT_ALT  = 2'd2,
        PAT_RSVD = 2'd3
    } pat_sel_e;

endpackage

// File: rtl/frame_timer.sv
// frame_timer: counts bit positions within a word and derives the frame
// marker, the bit clock level and the boundary load pulse.
// Assumes bit_en pulses once per bit; pwr_dn restarts framing like reset.
module frame_timer #(
    parameter int WORD_W = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic pwr_dn,
    output logic load,
    output logic frame_mk,
    output logic bclk
);
    localparam int POS_W = $clog2(WORD_W);
    localparam int LAST  = WORD_W - 1;
    localparam int HALF  = WORD_W / 2;

    logic [POS_W-1:0] pos;
    logic             idle;

    // Bit position: parked on the last position until the first pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || pwr_dn) begin
            pos  <= POS_W'(LAST);
            idle <= 1'b1;
        end else if (bit_en) begin
            idle <= 1'b0;
            if (pos == POS_W'(LAST)) pos <= '0;
            else                     pos <= pos + 1'b1;
        end
    end

    // Boundary pulse, marker and clock level decoded from the position.
    always_comb begin
        load     = bit_en && !pwr_dn && (pos == POS_W'(LAST));
        frame_mk = !idle && (pos < POS_W'(HALF));
        bclk     = !idle && !pos[0];
    end

endmodule

// File: rtl/word_stage.sv
// word_stage: holds the most recent parallel word from each channel until
// the next frame boundary takes it. Assumes smp_stb is a one-cycle strobe.
module word_stage #(
    parameter int LANES  = 4,
    parameter int WORD_W = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_stb,
    input  logic [LANES*WORD_W-1:0] smp_data,
    output logic [LANES*WORD_W-1:0] staged
);
    // Staging capture: a later strobe overwrites an earlier one.
    always_ff @(posedge clk) begin
        if (!rst_n)       staged <= '0;
        else if (smp_stb) staged <= smp_data;
    end

endmodule

// File: rtl/word_picker.sv
// word_picker: per lane, chooses between the staged word and the fixed test
// words. Assumes the select is used only at load time.
module word_picker
    import framer_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int WORD_W = 12
) (
    input  pat_sel_e                sel,
    input  logic [LANES*WORD_W-1:0] staged,
    output logic [LANES*WORD_W-1:0] picked
);
    logic [WORD_W-1:0] mid_word;
    logic [WORD_W-1:0] alt_word;

    // Test words: MSB alone set, and every odd bit set.
    always_comb begin
        mid_word = '0;
        mid_word[WORD_W-1] = 1'b1;
        for (int i = 0; i < WORD_W; i++) alt_word[i] = (i % 2) == 1;
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        // Word choice for this lane.
        always_comb begin
            case (sel)
                PAT_MID: picked[l*WORD_W +: WORD_W] = mid_word;
                PAT_ALT: picked[l*WORD_W +: WORD_W] = alt_word;
                default: picked[l*WORD_W +: WORD_W] = staged[l*WORD_W +: WORD_W];
            endcase
        end
    end

endmodule

// File: rtl/lane_shifter.sv
// lane_shifter: one shift register per lane, loaded at a frame boundary and
// shifted MSB first on every later bit pulse. Cleared by power-down.
module lane_shifter #(
    parameter int LANES  = 4,
    parameter int WORD_W = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    pwr_dn,
    input  logic                    bit_en,
    input  logic                    load,
    input  logic [LANES*WORD_W-1:0] picked,
    output logic [LANES-1:0]        lane_sd
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [WORD_W-1:0] shreg;

        // Load, shift or clear this lane's register.
        always_ff @(posedge clk) begin
            if (!rst_n || pwr_dn) shreg <= '0;
            else if (load)        shreg <= picked[l*WORD_W +: WORD_W];
            else if (bit_en)      shreg <= {shreg[WORD_W-2:0], 1'b0};
        end

        assign lane_sd[l] = shreg[WORD_W-1];
    end

endmodule

// File: rtl/adc_lane_framer.sv
// adc_lane_framer: serializes one parallel word per channel onto parallel
// lanes that share a bit clock and a frame marker. Assumes a single clock
// domain in which bit_en marks the serial bit rate.
module adc_lane_framer
    import framer_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int WORD_W = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bit_en,
    input  logic                    smp_stb,
    input  logic [LANES*WORD_W-1:0] smp_data,
    input  logic [1:0]              pat_sel,
    input  logic                    pwr_dn,
    output logic [LANES-1:0]        lane_sd,
    output logic                    frame_mk,
    output logic                    bclk,
    output logic                    out_en
);
    localparam int BUS_W = LANES * WORD_W;

    logic             load;
    logic [BUS_W-1:0] staged;
    logic [BUS_W-1:0] picked;
    pat_sel_e         sel;

    assign sel = pat_sel_e'(pat_sel);

    frame_timer #(.WORD_W(WORD_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .pwr_dn(pwr_dn),
        .load(load), .frame_mk(frame_mk), .bclk(bclk)
    );

    word_stage #(.LANES(LANES), .WORD_W(WORD_W)) u_stage (
        .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .smp_data(smp_data),
        .staged(staged)
    );

    word_picker #(.LANES(LANES), .WORD_W(WORD_W)) u_pick (
        .sel(sel), .staged(staged), .picked(picked)
    );

    lane_shifter #(.LANES(LANES), .WORD_W(WORD_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .bit_en(bit_en),
        .load(load), .picked(picked), .lane_sd(lane_sd)
    );

    // Output enable follows power-down one edge later.
    always_ff @(posedge clk) begin
        if (!rst_n) out_en <= 1'b0;
        else        out_en <= !pwr_dn;
    end

endmodule

// File: rtl/framer_checks.sv
// framer_checks: temporal properties of the framer ports, bound to the top.
module framer_checks #(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bit_en,
    input logic             pwr_dn,
    input logic [LANES-1:0] lane_sd,
    input logic             frame_mk,
    input logic             bclk,
    input logic             out_en
);
    // R3: each bit pulse flips the clock level
    a_r3_clock_flips: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !pwr_dn) |=> (bclk != $past(bclk)));

    // R2: the marker rises at an even position (clock high)
    a_r2_marker_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_mk) |-> $rose(bclk));

    // R2: the marker falls at an even position too (position 6)
    a_r2_marker_fall: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(frame_mk) && !$past(pwr_dn)) |-> $rose(bclk));

    // R10: power-down idles every output
    a_r10_pd_idle: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_dn |=> (!out_en && lane_sd == '0 && !frame_mk && !bclk));

    // R10: the enable returns after power-down ends
    a_r10_wake: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_dn |=> out_en);

    // R12: nothing moves without a bit pulse
    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_en && !pwr_dn) |=> ($stable(lane_sd) && $stable(frame_mk) && $stable(bclk)));

endmodule

bind adc_lane_framer framer_checks #(.LANES(LANES)) i_checks (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .pwr_dn(pwr_dn),
    .lane_sd(lane_sd), .frame_mk(frame_mk), .bclk(bclk), .out_en(out_en)
);

// File: tb/test_adc_lane_framer.sv
module test_adc_lane_framer;
    localparam int LANES  = 4;
    localparam int WORD_W = 12;
    localparam int BUS_W  = LANES * WORD_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bit_en = 1'b0;
    logic             smp_stb = 1'b0;
    logic [BUS_W-1:0] smp_data = '0;
    logic [1:0]       pat_sel = 2'd0;
    logic             pwr_dn = 1'b0;
    logic [LANES-1:0] lane_sd;
    logic             frame_mk;
    logic             bclk;
    logic             out_en;

    adc_lane_framer #(.LANES(LANES), .WORD_W(WORD_W)) i_adc_lane_framer (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .smp_stb(smp_stb),
        .smp_data(smp_data), .pat_sel(pat_sel), .pwr_dn(pwr_dn),
        .lane_sd(lane_sd), .frame_mk(frame_mk), .bclk(bclk), .out_en(out_en)
    );

    always #10 clk = ~clk;

    int               n_chk = 0;
    int               n_fail = 0;
    logic             run = 1'b0;
    logic             mon_on = 1'b0;
    logic             collecting = 1'b0;
    int               idx = 0;
    logic             mk_prev = 1'b0;
    logic             bc_prev = 1'b0;
    logic [LANES-1:0] sd_prev = '0;
    logic [BUS_W-1:0] got = '0;
    logic [BUS_W-1:0] exp_q[$];
    string            tag_q[$];
    event             ev_start;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [BUS_W-1:0] act, input logic [BUS_W-1:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    function automatic logic [BUS_W-1:0] expect_of(input logic [BUS_W-1:0] d,
                                                    input logic [1:0] p);
        logic [BUS_W-1:0] r;
        for (int l = 0; l < LANES; l++) begin
            case (p)
                2'd1:    r[l*WORD_W +: WORD_W] = 12'h800;
                2'd2:    r[l*WORD_W +: WORD_W] = 12'hAAA;
                default: r[l*WORD_W +: WORD_W] = d[l*WORD_W +: WORD_W];
            endcase
        end
        return r;
    endfunction

    // Monitor: sample after each edge, rebuild words, compare with the queue.
    always @(negedge clk) begin
        if (mon_on) begin
            if (bit_en) begin
                if (frame_mk && !mk_prev) begin
                    idx = 0;
                    collecting = 1'b1;
                    -> ev_start;
                end
                if (collecting) begin
                    // R2, R9: marker in first half; R3, R9: clock high on even bits
                    check(frame_mk == (idx < WORD_W/2), "R2", "frame marker",
                          BUS_W'(frame_mk), BUS_W'(idx < WORD_W/2));
                    check(bclk == (idx % 2 == 0), "R3", "bit clock level",
                          BUS_W'(bclk), BUS_W'(idx % 2 == 0));
                    for (int l = 0; l < LANES; l++)
                        got[l*WORD_W + (WORD_W-1-idx)] = lane_sd[l];
                    idx++;
                    if (idx == WORD_W) begin
                        collecting = 1'b0;
                        if (exp_q.size() == 0) begin
                            check(1'b0, "R4", "frame with no expected word", got, '0);
                        end else begin
                            check(got == exp_q[0], tag_q[0], "lane words", got, exp_q[0]);
                            void'(exp_q.pop_front());
                            void'(tag_q.pop_front());
                        end
                    end
                end
            end else begin
                // R12: no pulse, no movement
                check(lane_sd == sd_prev && frame_mk == mk_prev && bclk == bc_prev,
                      "R12", "hold without bit pulse",
                      BUS_W'({lane_sd, frame_mk, bclk}), BUS_W'({sd_prev, mk_prev, bc_prev}));
            end
        end
        mk_prev = frame_mk;
        bc_prev = bclk;
        sd_prev = lane_sd;
        bit_en  = run ? ~bit_en : 1'b0;
    end

    // Driver: strobe a word and push what the lanes should carry.
    task automatic post(input logic [BUS_W-1:0] d, input logic [1:0] p, input string tag);
        smp_data = d;
        pat_sel  = p;
        smp_stb  = 1'b1;
        @(negedge clk);
        smp_stb  = 1'b0;
        exp_q.push_back(expect_of(d, p));
        tag_q.push_back(tag);
    endtask

    task automatic send(input logic [BUS_W-1:0] d, input logic [1:0] p, input string tag);
        @(ev_start);
        repeat (3) @(negedge clk);
        post(d, p, tag);
    endtask

    // R5: two strobes in one frame, only the second is expected.
    task automatic send_twice(input logic [BUS_W-1:0] junk, input logic [BUS_W-1:0] d);
        @(ev_start);
        repeat (3) @(negedge clk);
        smp_data = junk;
        pat_sel  = 2'd0;
        smp_stb  = 1'b1;
        @(negedge clk);
        smp_stb  = 1'b0;
        repeat (4) @(negedge clk);
        post(d, 2'd0, "R5");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        check(!out_en && lane_sd == '0 && !frame_mk && !bclk, "R11", "reset outputs",
              BUS_W'({out_en, lane_sd, frame_mk, bclk}), '0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_en, "R10", "enable after reset", BUS_W'(out_en), BUS_W'(1));
        post(48'h123_456_789_ABC, 2'd0, "R1");
        run    = 1'b1;
        mon_on = 1'b1;
        send(48'hFFF_000_800_7FF, 2'd0, "R4");
        send(48'h000_FFF_001_FFE, 2'd0, "R1");
        send(48'h555_0F0_F0F_3C3, 2'd1, "R6");
        send(48'h9A5_111_222_333, 2'd2, "R7");
        send(48'hC01_EDB_246_8AC, 2'd3, "R8");
        send_twice(48'hBAD_BAD_BAD_BAD, 48'h0F1_E2D_3C4_B5A);
        send(48'h7FF_800_000_FFF, 2'd0, "R8");
        while (exp_q.size() != 0) @(negedge clk);
        mon_on = 1'b0;
        run    = 1'b0;
        repeat (2) @(negedge clk);
        pwr_dn = 1'b1;
        repeat (2) @(negedge clk);
        // R10: idle while powered down
        check(!out_en && lane_sd == '0 && !frame_mk && !bclk, "R10", "power-down outputs",
              BUS_W'({out_en, lane_sd, frame_mk, bclk}), '0);
        pwr_dn = 1'b0;
        @(negedge clk);
        check(out_en, "R10", "enable after power-down", BUS_W'(out_en), BUS_W'(1));
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(20 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule